// File: doc/BRIEF.md
# Digit-Serial Block-Matching SAD Comparator

The block scores candidate 4x4 reference blocks against one current 4x4 block and keeps the candidate with the smallest sum of absolute differences (SAD). The SAD of each candidate is not consumed as a plain binary number. It is produced as a stream of radix-2 signed digits, most significant first. After every digit, a comparator takes the partial value so far and bounds what the remaining digits can still add or take away. As soon as the candidate cannot beat the best one kept so far, it is dropped and its low-order digit cycles are never spent. The winner is still exactly the candidate that an exhaustive full-precision search would pick.

A search is a run of candidates whose last one is flagged. Each candidate is offered with a valid/ready handshake together with its 16 reference pixels and an index. The current block is sampled with every candidate. The first candidate of a search always runs to completion and seeds the best. When the last candidate has been resolved, a one-cycle done pulse marks the final best index and SAD. A running count of skipped digit cycles shows how much work the pruning saved.

Top module: `msd_sad_cmp`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, cand_ready is 1, done is 0, and best_idx, best_sad and skip_count are all 0.
- R2: A candidate's SAD is the sum over 16 pixel pairs of |cur - ref|. Pixels are 8-bit unsigned. Pixel i occupies bits [8i+7:8i] of cur_pix and of ref_pix. best_sad always reports the exact SAD of the held best and never exceeds 4080.
- R3: The SAD is expanded into 13 signed digits d12..d0, with d_k = b(k-1) - b(k), where b is the binary SAD and b(-1) = b(12) = 0. After the candidate is accepted there are two cycles of latency. One digit is then consumed per cycle, d12 first. A candidate that is not dropped resolves on the 14th rising edge after its accepting edge.
- R4: After consuming digit k, let P be the signed value of digits d12..dk. A candidate that is not the first of its search is dropped when P*2^k - (2^k - 1) >= the held best SAD. It then resolves on the (14-k)th edge after acceptance.
- R5: The first candidate of a search is never dropped. On resolving, it becomes the best, with its own index and SAD.
- R6: A later candidate whose SAD equals the held best does not replace it, so the earlier accepted index is kept.
- R7: When done pulses, best_idx and best_sad name the candidate with the minimum SAD in the search, choosing the earliest accepted one on ties.
- R8: cand_ready is 1 exactly when no candidate is in flight. A candidate is taken on a rising edge where cand_valid and cand_ready are both 1. cand_ready is 0 from then until the edge that resolves it.
- R9: done is 1 for exactly the one cycle after the edge that resolves a candidate flagged by cand_last. The next accepted candidate opens a new search.
- R10: skip_count grows by k when a candidate is dropped after digit k, and it is otherwise unchanged. It counts modulo 2^16 from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Block idle, can take a candidate |
| cand_idx | input | 8 | Candidate index |
| cand_last | input | 1 | Candidate is the last of its search |
| cur_pix | input | 128 | Current block, 16 pixels of 8 bits |
| ref_pix | input | 128 | Candidate block, 16 pixels of 8 bits |
| done | output | 1 | Search finished, best outputs final |
| best_idx | output | 8 | Index of the best candidate |
| best_sad | output | 12 | SAD of the best candidate |
| skip_count | output | 16 | Digit cycles skipped by pruning |

## Verification
Every result of this block lands a fixed number of edges after the accepting edge. A candidate dropped after digit k resolves on edge 14-k, and a candidate that runs to completion resolves on edge 14. At that same edge the best outputs and the skip count update and cand_ready rises, and done follows in the next cycle. The bench model works out k for each accepted candidate on its own and counts down edges from acceptance. Outputs are compared on every falling edge, so each value is checked half a cycle after the edge that set it. Directed cases also measure how many cycles cand_ready stays low, for a full candidate and for one dropped on its first digit.

// File: rtl/msd_sad_pkg.sv
package msd_sad_pkg;
  // Control flow for one candidate: capture differences, form digits, scan digits
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_DIGIT = 2'd2
  } cmp_state_e;
endpackage

// File: rtl/msd_absdiff.sv
module msd_absdiff #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 16
) (
  input  logic [NPIX*PIX_W-1:0] a_pix,
  input  logic [NPIX*PIX_W-1:0] b_pix,
  output logic [NPIX*PIX_W-1:0] abs_pix
);
  for (genvar i = 0; i < NPIX; i++) begin : g_pix
    logic [PIX_W-1:0] a_v, b_v;
    assign a_v = a_pix[i*PIX_W +: PIX_W];
    assign b_v = b_pix[i*PIX_W +: PIX_W];
    assign abs_pix[i*PIX_W +: PIX_W] = (a_v >= b_v) ? (a_v - b_v) : (b_v - a_v);
  end
endmodule

// File: rtl/msd_sad_sum.sv
module msd_sad_sum #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 16,
  localparam int SAD_W = PIX_W + $clog2(NPIX)
) (
  input  logic [NPIX*PIX_W-1:0] abs_pix,
  output logic [SAD_W-1:0]      sad
);
  always_comb begin
    sad = '0;
    for (int i = 0; i < NPIX; i++) begin
      sad = sad + SAD_W'(abs_pix[i*PIX_W +: PIX_W]);
    end
  end
endmodule

// File: rtl/msd_sd_recode.sv
module msd_sd_recode #(
  parameter int SAD_W = 12,
  localparam int NDIG = SAD_W + 1
) (
  input  logic [SAD_W-1:0] sad,
  output logic [NDIG-1:0]  dig_p,
  output logic [NDIG-1:0]  dig_m
);
  // ext[j] holds binary bit j-1; ext[0] and ext[SAD_W+1] are zero
  logic [SAD_W+1:0] ext;
  assign ext = {1'b0, sad, 1'b0};

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    // digit k = bit(k-1) - bit(k)
    assign dig_p[k] = ext[k] & ~ext[k+1];
    assign dig_m[k] = ~ext[k] & ext[k+1];
  end
endmodule

// File: rtl/msd_digit_prune.sv
module msd_digit_prune #(
  parameter int SAD_W = 12,
  localparam int NDIG  = SAD_W + 1,
  localparam int POS_W = $clog2(NDIG),
  localparam int PW    = SAD_W + 3
) (
  input  logic signed [PW-1:0]    part_q,
  input  logic                    dp,
  input  logic                    dm,
  input  logic [POS_W-1:0]        pos,
  input  logic [SAD_W-1:0]        best_sad,
  input  logic                    seed,
  output logic signed [PW-1:0]    part_next,
  output logic [SAD_W-1:0]        exact_sad,
  output logic                    lose
);
  logic signed [PW-1:0] dig_v;
  logic signed [PW-1:0] slack;
  logic signed [PW-1:0] low_bound;
  logic signed [PW-1:0] best_s;

  always_comb begin
    dig_v     = dp ? PW'(1) : (dm ? -PW'(1) : '0);
    part_next = (part_q <<< 1) + dig_v;
    slack     = (PW'(1) << pos) - PW'(1);
    low_bound = (part_next <<< pos) - slack;
    best_s    = $signed({3'b000, best_sad});
    lose      = !seed && (low_bound >= best_s);
    exact_sad = part_next[SAD_W-1:0];
  end
endmodule

// File: rtl/msd_sad_cmp.sv
module msd_sad_cmp
  import msd_sad_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int NPIX  = 16,
  parameter int IDX_W = 8,
  parameter int CNT_W = 16,
  localparam int SAD_W = PIX_W + $clog2(NPIX)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cand_valid,
  output logic                    cand_ready,
  input  logic [IDX_W-1:0]        cand_idx,
  input  logic                    cand_last,
  input  logic [NPIX*PIX_W-1:0]   cur_pix,
  input  logic [NPIX*PIX_W-1:0]   ref_pix,
  output logic                    done,
  output logic [IDX_W-1:0]        best_idx,
  output logic [SAD_W-1:0]        best_sad,
  output logic [CNT_W-1:0]        skip_count
);
  localparam int NDIG  = SAD_W + 1;
  localparam int POS_W = $clog2(NDIG);
  localparam int PW    = SAD_W + 3;
  localparam int PIXB  = NPIX * PIX_W;

  // ---------------- state ----------------
  cmp_state_e            state_q, state_d;
  logic [PIXB-1:0]       abs_q, abs_d;
  logic [NDIG-1:0]       dp_q, dp_d, dm_q, dm_d;
  logic [POS_W-1:0]      pos_q, pos_d;
  logic signed [PW-1:0]  part_q, part_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic                  last_q, last_d;
  logic                  seed_q, seed_d;
  logic                  first_q, first_d;
  logic                  done_q, done_d;
  logic [IDX_W-1:0]      bidx_q, bidx_d;
  logic [SAD_W-1:0]      bsad_q, bsad_d;
  logic [CNT_W-1:0]      skip_q, skip_d;

  // ---------------- datapath ----------------
  logic [PIXB-1:0]       abs_c;
  logic [SAD_W-1:0]      sad_c;
  logic [NDIG-1:0]       dp_c, dm_c;
  logic signed [PW-1:0]  part_nx;
  logic [SAD_W-1:0]      exact_c;
  logic                  lose_c;

  msd_absdiff #(.PIX_W(PIX_W), .NPIX(NPIX)) u_absdiff (
    .a_pix   (cur_pix),
    .b_pix   (ref_pix),
    .abs_pix (abs_c)
  );

  msd_sad_sum #(.PIX_W(PIX_W), .NPIX(NPIX)) u_sum (
    .abs_pix (abs_q),
    .sad     (sad_c)
  );

  msd_sd_recode #(.SAD_W(SAD_W)) u_recode (
    .sad   (sad_c),
    .dig_p (dp_c),
    .dig_m (dm_c)
  );

  msd_digit_prune #(.SAD_W(SAD_W)) u_prune (
    .part_q    (part_q),
    .dp        (dp_q[pos_q]),
    .dm        (dm_q[pos_q]),
    .pos       (pos_q),
    .best_sad  (bsad_q),
    .seed      (seed_q),
    .part_next (part_nx),
    .exact_sad (exact_c),
    .lose      (lose_c)
  );

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    abs_d   = abs_q;
    dp_d    = dp_q;
    dm_d    = dm_q;
    pos_d   = pos_q;
    part_d  = part_q;
    idx_d   = idx_q;
    last_d  = last_q;
    seed_d  = seed_q;
    first_d = first_q;
    done_d  = 1'b0;
    bidx_d  = bidx_q;
    bsad_d  = bsad_q;
    skip_d  = skip_q;

    unique case (state_q)
      ST_IDLE: begin
        if (cand_valid) begin
          abs_d   = abs_c;
          idx_d   = cand_idx;
          last_d  = cand_last;
          seed_d  = first_q;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        dp_d    = dp_c;
        dm_d    = dm_c;
        pos_d   = POS_W'(NDIG - 1);
        part_d  = '0;
        state_d = ST_DIGIT;
      end
      ST_DIGIT: begin
        part_d = part_nx;
        if (lose_c || (pos_q == '0)) begin
          if (lose_c) begin
            skip_d = skip_q + CNT_W'(pos_q);
          end else begin
            bsad_d = exact_c;
            bidx_d = idx_q;
          end
          done_d  = last_q;
          first_d = last_q;
          state_d = ST_IDLE;
        end else begin
          pos_d = pos_q - POS_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      abs_q   <= '0;
      dp_q    <= '0;
      dm_q    <= '0;
      pos_q   <= '0;
      part_q  <= '0;
      idx_q   <= '0;
      last_q  <= 1'b0;
      seed_q  <= 1'b0;
      first_q <= 1'b1;
      done_q  <= 1'b0;
      bidx_q  <= '0;
      bsad_q  <= '0;
      skip_q  <= '0;
    end else begin
      state_q <= state_d;
      abs_q   <= abs_d;
      dp_q    <= dp_d;
      dm_q    <= dm_d;
      pos_q   <= pos_d;
      part_q  <= part_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      seed_q  <= seed_d;
      first_q <= first_d;
      done_q  <= done_d;
      bidx_q  <= bidx_d;
      bsad_q  <= bsad_d;
      skip_q  <= skip_d;
    end
  end

  assign cand_ready = (state_q == ST_IDLE);
  assign done       = done_q;
  assign best_idx   = bidx_q;
  assign best_sad   = bsad_q;
  assign skip_count = skip_q;
endmodule

// File: rtl/msd_sad_cmp_chk.sv
module msd_sad_cmp_chk #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 16,
  parameter int IDX_W = 8,
  parameter int CNT_W = 16,
  localparam int SAD_W = PIX_W + $clog2(NPIX)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cand_valid,
  input logic              cand_ready,
  input logic              done,
  input logic [IDX_W-1:0]  best_idx,
  input logic [SAD_W-1:0]  best_sad,
  input logic [CNT_W-1:0]  skip_count
);
  localparam int MAX_SAD = NPIX * ((1 << PIX_W) - 1);

  // R8: an accepted candidate makes the block busy
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && cand_ready |=> !cand_ready);

  // R3: two cycles of latency before any digit can resolve the candidate
  p_online_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && cand_ready |=> !cand_ready ##1 !cand_ready);

  // R9: done lasts exactly one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done comes with the block idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cand_ready);

  // R10: idle cycles without an offer change no result
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cand_ready && !cand_valid |=> $stable(skip_count) && $stable(best_sad) && $stable(best_idx));

  // R2: the reported SAD stays within the pixel range
  p_sad_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    best_sad <= SAD_W'(MAX_SAD));
endmodule

bind msd_sad_cmp msd_sad_cmp_chk #(
  .PIX_W(PIX_W), .NPIX(NPIX), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cand_valid (cand_valid),
  .cand_ready (cand_ready),
  .done       (done),
  .best_idx   (best_idx),
  .best_sad   (best_sad),
  .skip_count (skip_count)
);

// File: tb/msd_sad_cmp_bench.sv
`timescale 1ns/1ps
module msd_sad_cmp_bench;
  localparam int NPIX = 16;
  localparam int TOPD = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cand_valid;
  logic         cand_ready;
  logic [7:0]   cand_idx;
  logic         cand_last;
  logic [127:0] cur_pix;
  logic [127:0] ref_pix;
  logic         done;
  logic [7:0]   best_idx;
  logic [11:0]  best_sad;
  logic [15:0]  skip_count;

  always #10 clk = ~clk;

  msd_sad_cmp u_msd_sad_cmp (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_idx(cand_idx), .cand_last(cand_last), .cur_pix(cur_pix), .ref_pix(ref_pix),
    .done(done), .best_idx(best_idx), .best_sad(best_sad), .skip_count(skip_count)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sad_of(input logic [127:0] a, input logic [127:0] b);
    int s = 0;
    for (int i = 0; i < NPIX; i++) begin
      int x = int'(a[i*8 +: 8]);
      int y = int'(b[i*8 +: 8]);
      s += (x > y) ? x - y : y - x;
    end
    return s;
  endfunction

  // Digit position at which a candidate stops (R4); win set when it replaces the best
  function automatic int stop_pos(input int sad, input int best, input bit first, output bit win);
    int p = 0;
    for (int k = TOPD; k >= 0; k--) begin
      int bk  = (sad >> k) & 1;
      int bk1 = (k > 0) ? ((sad >> (k - 1)) & 1) : 0;
      p = 2 * p + (bk1 - bk);
      if (!first && (p * (1 << k) - ((1 << k) - 1) >= best)) begin
        win = 1'b0;
        return k;
      end
    end
    win = 1'b1;
    return 0;
  endfunction

  // ---------------- reference model ----------------
  bit m_busy, m_win, m_last, m_first, m_done;
  int m_cnt, m_k, m_sad, m_idx, m_bsad, m_bidx, m_skip;
  int ex_sad, ex_idx;
  int q_sad[$];
  int q_idx[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_first = 1; m_done = 0;
      m_bsad = 0; m_bidx = 0; m_skip = 0; m_cnt = 0;
      q_sad.delete(); q_idx.delete();
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          if (m_win) begin m_bsad = m_sad; m_bidx = m_idx; end
          else m_skip += m_k;
          if (m_last) begin
            m_done = 1;
            ex_sad = q_sad[0]; ex_idx = q_idx[0];
            foreach (q_sad[i]) if (q_sad[i] < ex_sad) begin ex_sad = q_sad[i]; ex_idx = q_idx[i]; end
            q_sad.delete(); q_idx.delete();
          end
          m_first = m_last;
        end
      end else if (cand_valid) begin
        m_sad  = sad_of(cur_pix, ref_pix);
        m_idx  = int'(cand_idx);
        m_last = cand_last;
        m_k    = stop_pos(m_sad, m_bsad, m_first, m_win);
        m_cnt  = 14 - m_k;
        m_busy = 1;
        q_sad.push_back(m_sad);
        q_idx.push_back(m_idx);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(cand_ready == !m_busy, "R8 cand_ready", int'(cand_ready), int'(!m_busy));
      check(done == m_done, "R9 done", int'(done), int'(m_done));
      check(int'(best_sad) == m_bsad, "R2 best_sad", int'(best_sad), m_bsad);
      check(int'(best_idx) == m_bidx, "R6 best_idx", int'(best_idx), m_bidx);
      check(skip_count == 16'(m_skip), "R10 skip_count", int'(skip_count), m_skip);
      if (m_done) begin
        check(int'(best_idx) == ex_idx, "R7 exhaustive index", int'(best_idx), ex_idx);
        check(int'(best_sad) == ex_sad, "R7 exhaustive sad", int'(best_sad), ex_sad);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input int idx, input bit last, input logic [127:0] r);
    cand_valid = 1'b1; cand_idx = 8'(idx); cand_last = last; ref_pix = r;
    while (!cand_ready) @(negedge clk);
    @(negedge clk);
    cand_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (!cand_ready) begin n++; @(negedge clk); end
  endtask

  function automatic logic [127:0] noisy(input logic [127:0] c, input int amp);
    logic [127:0] r;
    for (int i = 0; i < NPIX; i++) begin
      int v = int'(c[i*8 +: 8]) + $urandom_range(0, 2 * amp) - amp;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      r[i*8 +: 8] = 8'(v);
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    int n, s0, sk;
    logic [127:0] r;
    rst_n = 1'b0; cand_valid = 1'b0; cand_idx = '0; cand_last = 1'b0;
    cur_pix = '0; ref_pix = '0;
    repeat (3) @(negedge clk);
    check(cand_ready && !done && best_idx == 0 && best_sad == 0 && skip_count == 0,
          "R1 reset outputs", int'(best_sad), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cand_ready && !done && best_idx == 0 && best_sad == 0 && skip_count == 0,
          "R1 after release", int'(skip_count), 0);

    // Full-length first candidate, then a perfect match closes the search
    cur_pix = rnd128();
    r = rnd128();
    s0 = sad_of(cur_pix, r);
    send(3, 1'b0, r);
    wait_idle(n);
    check(n == 14, "R3 full candidate cycles", n, 14);
    check(int'(best_sad) == s0 && best_idx == 3, "R5 first becomes best", int'(best_sad), s0);
    send(4, 1'b1, cur_pix);
    wait_idle(n);
    @(negedge clk);

    // Perfect seed, then a far block dropped on its first digit, then a tie
    cur_pix = rnd128();
    send(10, 1'b0, cur_pix);
    wait_idle(n);
    sk = int'(skip_count);
    send(11, 1'b0, cur_pix ^ {16{8'h80}});
    wait_idle(n);
    check(n == 2, "R4 dropped after top digit", n, 2);
    check(int'(skip_count) == sk + 12, "R10 skip grows by 12", int'(skip_count), sk + 12);
    send(12, 1'b1, cur_pix);
    wait_idle(n);
    check(best_idx == 10, "R6 tie at zero keeps earlier", int'(best_idx), 10);
    @(negedge clk);

    // Nonzero tie
    cur_pix = rnd128();
    r = cur_pix ^ {16{8'h0F}};
    send(20, 1'b0, r);
    send(21, 1'b1, r);
    wait_idle(n);
    check(best_idx == 20, "R6 tie keeps earlier", int'(best_idx), 20);
    @(negedge clk);

    // Random searches, offered back to back
    for (int s = 0; s < 6; s++) begin
      cur_pix = rnd128();
      for (int c = 0; c < 7; c++) begin
        case ($urandom_range(0, 2))
          0: r = rnd128();
          1: r = noisy(cur_pix, 4);
          default: r = noisy(cur_pix, 40);
        endcase
        send(s * 16 + c, (c == 6), r);
      end
      wait_idle(n);
      @(negedge clk);
    end

    check(skip_count != 0, "R4 pruning took effect", int'(skip_count), 1);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule